// File: doc/BRIEF.md
# Nine-Bit Serial Panel Bring-Up Sequencer

This block brings an LCD controller up and takes it down again over a serial link that only writes. Every word on the link is nine bits wide. The top bit tells the controller how to read the other eight: a 0 marks a command byte and a 1 marks a data byte. A pulse on `start_up` plays the power-up script. A pulse on `shut_down` plays the power-down script. Both scripts are held in a small internal table. Each table step holds a command byte, a count of zero, one or two data bytes, a 16-bit data value and a flag that requests a long pause after the step.

Each step is sent as one chip-select window holding one, two or three words. The serial clock idles high. Data changes while the clock is low and is sampled on the rising edge (SPI mode 3). A system-clock divider sets the serial clock rate. A parameterised counter sets the length of the long pause. While a script runs, `busy` is high. When the final step finishes, `done` pulses for one cycle.

All control and status pins are plain levels or pulses. The block has no streaming interface, so no valid/ready handshake and no back-pressure are involved.

Top module: `panel_init_seq`

## Requirements
- R1: Each word is 9 bits, sent MSB first. Bit 8 is 0 for the command byte and 1 for every data byte.
- R2: `sclk` is high whenever `cs_n` is high. `mosi` never changes in the cycle where `sclk` rises.
- R3: One step is one window with `cs_n` low throughout. The window carries the command word, then 0, 1 or 2 data words. A 16-bit value goes high byte first. A 1-byte value uses the low byte.
- R4: Between two windows, `cs_n` stays high for at least 2*SCLK_HALF system cycles.
- R5: The power-up script sends 15 windows in this order: 00, 00, 00, B0:17, BC:80, 3B:00, B0:16, B8:FFF9, 11, BA:01, 3A:60, BD:04, C7:5533, EC:01F0, 29.
- R6: After each of the first three power-up windows, `cs_n` stays high for at least WAIT_CYCLES cycles.
- R7: The power-down script sends 4 windows in this order: 28, B8:8002, 10, B0:00.
- R8: `busy` rises in the cycle after a request is accepted and stays high until the script ends. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R9: A request of either kind that arrives while `busy` is high is ignored. The running script is neither restarted nor extended.
- R10: If `start_up` and `shut_down` are both high in an idle cycle, the power-up script is the one that runs.
- R11: After reset, `cs_n`=1, `sclk`=1, `busy`=0 and `done`=0.
- R12: Each low phase of `sclk` lasts exactly SCLK_HALF system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_up | input | 1 | Request to run the power-up script |
| shut_down | input | 1 | Request to run the power-down script |
| busy | output | 1 | High while a script is running |
| done | output | 1 | One-cycle pulse at the end of a script |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the controller |
| cs_n | output | 1 | Chip select, active low |

## Verification
The bench builds the block with SCLK_HALF=2 and WAIT_CYCLES=40. The whole power-up script then finishes in a few thousand cycles. The long pauses stay far longer than the normal inter-window gap, so checking them against the 40-cycle bound tells the two gap kinds apart. A divider of 2 still gives a low phase of more than one cycle, so the exact low-phase width and the rule that `mosi` holds at the rising edge are tested for real. The bench decodes the bus itself into windows and words and compares them with its own script lists. It also sends colliding and mid-script requests to exercise priority and the ignore rule.

// File: rtl/pis_pkg.sv
package pis_pkg;
  localparam int WORD_W     = 9;
  localparam int STEPS      = 19;
  localparam int UP_FIRST   = 0;
  localparam int DOWN_FIRST = 15;
  localparam int IDX_W      = $clog2(STEPS + 1);

  typedef struct packed {
    logic [7:0]  cmd;
    logic [1:0]  nbytes;
    logic [15:0] val;
    logic        pause;
    logic        last;
  } step_t;

  function automatic step_t mk(input logic [7:0] c, input logic [1:0] n,
                               input logic [15:0] v, input logic p, input logic l);
    step_t s;
    s.cmd = c; s.nbytes = n; s.val = v; s.pause = p; s.last = l;
    return s;
  endfunction
endpackage

// File: rtl/pis_script.sv
module pis_script
  import pis_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  always_comb begin
    case (idx)
      // power-up
      5'd0:  step = mk(8'h00, 2'd0, 16'h0000, 1'b1, 1'b0);
      5'd1:  step = mk(8'h00, 2'd0, 16'h0000, 1'b1, 1'b0);
      5'd2:  step = mk(8'h00, 2'd0, 16'h0000, 1'b1, 1'b0);
      5'd3:  step = mk(8'hB0, 2'd1, 16'h0017, 1'b0, 1'b0);
      5'd4:  step = mk(8'hBC, 2'd1, 16'h0080, 1'b0, 1'b0);
      5'd5:  step = mk(8'h3B, 2'd1, 16'h0000, 1'b0, 1'b0);
      5'd6:  step = mk(8'hB0, 2'd1, 16'h0016, 1'b0, 1'b0);
      5'd7:  step = mk(8'hB8, 2'd2, 16'hFFF9, 1'b0, 1'b0);
      5'd8:  step = mk(8'h11, 2'd0, 16'h0000, 1'b0, 1'b0);
      5'd9:  step = mk(8'hBA, 2'd1, 16'h0001, 1'b0, 1'b0);
      5'd10: step = mk(8'h3A, 2'd1, 16'h0060, 1'b0, 1'b0);
      5'd11: step = mk(8'hBD, 2'd1, 16'h0004, 1'b0, 1'b0);
      5'd12: step = mk(8'hC7, 2'd2, 16'h5533, 1'b0, 1'b0);
      5'd13: step = mk(8'hEC, 2'd2, 16'h01F0, 1'b0, 1'b0);
      5'd14: step = mk(8'h29, 2'd0, 16'h0000, 1'b0, 1'b1);
      // power-down
      5'd15: step = mk(8'h28, 2'd0, 16'h0000, 1'b0, 1'b0);
      5'd16: step = mk(8'hB8, 2'd2, 16'h8002, 1'b0, 1'b0);
      5'd17: step = mk(8'h10, 2'd0, 16'h0000, 1'b0, 1'b0);
      5'd18: step = mk(8'hB0, 2'd1, 16'h0000, 1'b0, 1'b1);
      default: step = mk(8'h00, 2'd0, 16'h0000, 1'b0, 1'b1);
    endcase
  end
endmodule

// File: rtl/pis_bitshift.sv
module pis_bitshift #(
  parameter int HALF   = 4,
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] word,
  output logic              sclk,
  output logic              mosi,
  output logic              fin
);
  localparam int DIV_W = $clog2(HALF + 1);
  localparam int BIT_W = $clog2(WORD_W);

  logic              active, phase;
  logic [DIV_W-1:0]  div;
  logic [BIT_W-1:0]  left;
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; phase <= 1'b0; div <= '0; left <= '0; sh <= '0;
      sclk <= 1'b1; mosi <= 1'b1; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        active <= 1'b1;
        phase  <= 1'b0;
        div    <= '0;
        left   <= BIT_W'(WORD_W - 1);
        sh     <= {word[WORD_W-2:0], 1'b0};
        sclk   <= 1'b0;
        mosi   <= word[WORD_W-1];
      end else if (active) begin
        if (div == DIV_W'(HALF - 1)) begin
          div <= '0;
          if (!phase) begin
            sclk  <= 1'b1;
            phase <= 1'b1;
          end else if (left == '0) begin
            active <= 1'b0;
            fin    <= 1'b1;
          end else begin
            sclk  <= 1'b0;
            phase <= 1'b0;
            mosi  <= sh[WORD_W-1];
            sh    <= {sh[WORD_W-2:0], 1'b0};
            left  <= left - 1'b1;
          end
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import pis_pkg::*;
#(
  parameter int SCLK_HALF   = 4,
  parameter int WAIT_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_up,
  input  logic shut_down,
  output logic busy,
  output logic done,
  output logic sclk,
  output logic mosi,
  output logic cs_n
);
  localparam int GAP   = 2 * SCLK_HALF;
  localparam int MAXC  = (GAP > WAIT_CYCLES) ? GAP : WAIT_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WORD, S_GAP, S_PAUSE} st_t;

  st_t               st;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        wsel;
  logic [CNT_W-1:0]  tcnt;
  logic              cs_q, done_q, fin, step_end;
  step_t             step;
  logic [WORD_W-1:0] word;

  pis_script u_script (.idx(idx), .step(step));

  always_comb begin
    case (wsel)
      2'd0:    word = {1'b0, step.cmd};
      2'd1:    word = (step.nbytes == 2'd2) ? {1'b1, step.val[15:8]} : {1'b1, step.val[7:0]};
      default: word = {1'b1, step.val[7:0]};
    endcase
  end

  pis_bitshift #(.HALF(SCLK_HALF), .WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(st == S_SEND), .word(word),
    .sclk(sclk), .mosi(mosi), .fin(fin)
  );

  assign step_end = (st == S_GAP && tcnt == CNT_W'(GAP - 1) && !step.pause) ||
                    (st == S_PAUSE && tcnt == CNT_W'(WAIT_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; wsel <= '0; tcnt <= '0; cs_q <= 1'b1; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (step_end) begin
        if (step.last) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end else begin
          idx  <= idx + 1'b1;
          wsel <= '0;
          cs_q <= 1'b0;
          st   <= S_SEND;
        end
      end else begin
        case (st)
          S_IDLE: begin
            if (start_up || shut_down) begin
              idx  <= start_up ? IDX_W'(UP_FIRST) : IDX_W'(DOWN_FIRST);
              wsel <= '0;
              cs_q <= 1'b0;
              st   <= S_SEND;
            end
          end
          S_SEND: st <= S_WORD;
          S_WORD: begin
            if (fin) begin
              if (wsel == step.nbytes) begin
                cs_q <= 1'b1;
                tcnt <= '0;
                st   <= S_GAP;
              end else begin
                wsel <= wsel + 1'b1;
                st   <= S_SEND;
              end
            end
          end
          S_GAP: begin
            if (tcnt == CNT_W'(GAP - 1)) begin
              tcnt <= '0;
              st   <= S_PAUSE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          S_PAUSE: tcnt <= tcnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign busy = (st != S_IDLE);
  assign done = done_q;
  assign cs_n = cs_q;
endmodule

// File: rtl/pis_checker.sv
module pis_checker #(
  parameter int SCLK_HALF = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start_up,
  input logic shut_down,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic mosi,
  input logic cs_n
);
  localparam int GAP = 2 * SCLK_HALF;
  localparam int W   = $clog2(GAP + 2) + 1;

  logic [W-1:0] hicnt, lowcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hicnt  <= W'(GAP);
      lowcnt <= '0;
    end else begin
      hicnt  <= !cs_n ? '0 : (hicnt >= W'(GAP) ? hicnt : hicnt + 1'b1);
      lowcnt <= sclk ? '0 : lowcnt + 1'b1;
    end
  end

  assert_idle_clock_R2: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sclk);
  assert_mosi_hold_R2:  assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> $stable(mosi));
  assert_cs_in_run_R3:  assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);
  assert_cs_gap_R4:     assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> hicnt >= W'(GAP));
  assert_done_once_R8:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_done_idle_R8:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  assert_accept_R9:     assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start_up || shut_down));
  assert_low_phase_R12: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> lowcnt == W'(SCLK_HALF));
endmodule

bind panel_init_seq pis_checker #(.SCLK_HALF(SCLK_HALF)) u_chk (.*);

// File: tb/panel_init_seq_test.sv
module panel_init_seq_test;
  localparam int HALF = 2;
  localparam int WAITC = 40;

  logic clk = 1'b0, rst_n = 1'b0, start_up = 1'b0, shut_down = 1'b0;
  logic busy, done, sclk, mosi, cs_n;

  panel_init_seq #(.SCLK_HALF(HALF), .WAIT_CYCLES(WAITC)) uut (
    .clk(clk), .rst_n(rst_n), .start_up(start_up), .shut_down(shut_down),
    .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .cs_n(cs_n));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int exp_n[$], exp_w[$], got_n[$], got_w[$], gaps[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic add(input int c, input int n, input int v);
    exp_n.push_back(n + 1);
    exp_w.push_back(c & 8'hFF);
    if (n == 2) exp_w.push_back(9'h100 | ((v >> 8) & 8'hFF));
    if (n >= 1) exp_w.push_back(9'h100 | (v & 8'hFF));
  endtask

  // bus monitor: decodes windows and words, checks phase widths
  logic psclk = 1'b1, pcs = 1'b1, pmosi = 1'b1;
  int sh = 0, nbits = 0, wins = 0, lowrun = 0, hirun = 0;
  bit seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n) chk(sclk, "R2 idle clock", sclk, 1);
      if (sclk && !psclk) begin
        chk(mosi == pmosi, "R2 mosi stable at rise", mosi, pmosi);
        chk(lowrun == HALF, "R12 low phase", lowrun, HALF);
        if (!cs_n) begin
          sh = ((sh << 1) | mosi) & 9'h1FF;
          nbits++;
          if (nbits % 9 == 0) begin got_w.push_back(sh); wins++; end
        end
      end
      lowrun = sclk ? 0 : lowrun + 1;
      if (cs_n && !pcs) begin
        chk(nbits % 9 == 0, "R1 whole words", nbits, 9);
        got_n.push_back(nbits / 9);
        nbits = 0;
        hirun = 0;
      end
      if (!cs_n && pcs) begin
        if (seen) gaps.push_back(hirun);
        seen = 1;
      end
      if (cs_n) hirun++;
    end
    psclk = sclk; pcs = cs_n; pmosi = mosi;
  end

  task automatic clear_all();
    exp_n.delete(); exp_w.delete(); got_n.delete(); got_w.delete(); gaps.delete();
    seen = 0;
  endtask

  task automatic wait_done(input string req);
    int i;
    for (i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    chk(i < 20000, {req, " done reached"}, i, 0);
    chk(!busy, "R8 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  task automatic compare(input string req);
    int wi = 0;
    chk(got_n.size() == exp_n.size(), {req, " window count"}, got_n.size(), exp_n.size());
    for (int t = 0; t < exp_n.size() && t < got_n.size(); t++) begin
      chk(got_n[t] == exp_n[t], "R3 words per window", got_n[t], exp_n[t]);
      for (int k = 0; k < exp_n[t]; k++) begin
        if (wi < got_w.size() && wi < exp_w.size())
          chk(got_w[wi] == exp_w[wi], "R1 R3 word value", got_w[wi], exp_w[wi]);
        wi++;
      end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 1, "R11 reset bus", {cs_n, sclk}, 3);
    chk(busy == 0 && done == 0, "R11 reset status", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: both requests at once in idle -> power-up
    clear_all();
    add(8'h00,0,0); add(8'h00,0,0); add(8'h00,0,0);
    add(8'hB0,1,8'h17); add(8'hBC,1,8'h80); add(8'h3B,1,8'h00); add(8'hB0,1,8'h16);
    add(8'hB8,2,16'hFFF9); add(8'h11,0,0); add(8'hBA,1,8'h01); add(8'h3A,1,8'h60);
    add(8'hBD,1,8'h04); add(8'hC7,2,16'h5533); add(8'hEC,2,16'h01F0); add(8'h29,0,0);
    start_up = 1'b1; shut_down = 1'b1;
    @(negedge clk);
    start_up = 1'b0; shut_down = 1'b0;
    chk(busy, "R8 busy after accept", busy, 1);
    repeat (30) @(negedge clk);
    // R9: requests while busy are ignored
    shut_down = 1'b1; @(negedge clk); shut_down = 1'b0;
    repeat (200) @(negedge clk);
    start_up = 1'b1; @(negedge clk); start_up = 1'b0;
    wait_done("R5");
    compare("R5 R10");
    for (int g = 0; g < gaps.size(); g++) begin
      if (g < 3) chk(gaps[g] >= WAITC, "R6 long pause", gaps[g], WAITC);
      else       chk(gaps[g] >= 2*HALF, "R4 window gap", gaps[g], 2*HALF);
    end
    repeat (200) @(negedge clk);
    chk(got_n.size() == 15 && !busy, "R9 nothing after ignored requests", got_n.size(), 15);

    // R7: power-down
    clear_all();
    add(8'h28,0,0); add(8'hB8,2,16'h8002); add(8'h10,0,0); add(8'hB0,1,8'h00);
    shut_down = 1'b1; @(negedge clk); shut_down = 1'b0;
    chk(busy, "R8 busy after accept", busy, 1);
    wait_done("R7");
    compare("R7");
    for (int g = 0; g < gaps.size(); g++)
      chk(gaps[g] >= 2*HALF, "R4 window gap", gaps[g], 2*HALF);
    repeat (50) @(negedge clk);
    chk(got_n.size() == 4, "R7 no extra windows", got_n.size(), 4);
    finish_run();
  end
endmodule